// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block takes interrupt events from on-chip sources and stores each one as a 16-byte vector in a circular buffer in memory. Host software drains the buffer and reports its progress by updating a read pointer. Each event carries a source id, source data, a ring id, a VM id and a PASID. The block packs these into four 32-bit words, writes them through a simple memory write port and advances its byte-granular write pointer. It can then write the write-pointer word to a programmable writeback address so software can poll memory instead of a register. An interrupt line stays high while unread vectors are pending.

Software configures the block through a small word-addressed register port. Offset 0 is control, 1 is ring base, 2 is read pointer, 3 is write pointer, 4 is writeback address low and 5 is writeback address high. The read pointer can also be updated through a dedicated doorbell port. A control bit selects which of the two update paths is honoured. When the ring is full, the block keeps writing and overwrites the oldest entry. It also sets a sticky overflow flag that software sees in the write-pointer word.

Top module: `ivr_ring_writer`

## Requirements
- R1: An accepted event produces four consecutive memory writes to byte addresses {base,8'h00}+wptr+0, +4, +8 and +12, where wptr is the write pointer at acceptance. Word 0 carries the source id in [7:0]. Word 1 carries the source data in [27:0]. Word 2 carries the ring id in [7:0], the VM id in [15:8] and the PASID in [31:16]. Word 3 is zero, and all unused bits are zero.
- R2: After the fourth word, the write pointer becomes (wptr+16) & (ring bytes-1). The ring size in bytes is 4<<L, where L is control bits [8:4], clamped to the range 2..PTR_W-2. Reading offset 3 returns the pointer in its own bit positions, with the overflow flag in bit 0.
- R3: If (wptr+16)&mask equals the read pointer when an event is accepted, the overflow flag is set. The vector is still written and the pointer still advances. The flag stays set until software writes control with bit 31 set. Bit 31 reads back as 0.
- R4: irq is high exactly when the interrupt enable (control bit 1) is set and either the read pointer differs from the write pointer or the overflow flag is set.
- R5: When writeback is enabled (control bit 2), a vector's four words are followed in the next cycle by one write of the write-pointer word to the address {whi[7:0],wlo}. When writeback is disabled, no such write occurs.
- R6: ev_ready is high only when the ring is enabled (control bit 0) and no vector or writeback write is in progress. An accepted event holds ready low for 4 cycles, or 5 with writeback enabled. With the ring disabled, no event is accepted and nothing is written.
- R7: When the doorbell enable (control bit 3) is clear, only register writes to offset 2 update the read pointer. When it is set, only doorbell writes do. The stored read pointer is masked to the ring size and aligned to 16 bytes.
- R8: After reset, all registers read zero, irq is low and no memory write is issued. Software writing 0 to offsets 2 and 3 returns the ring to empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted when high together with ev_valid |
| ev_src_id | input | 8 | Event source id |
| ev_src_data | input | 28 | Event source data |
| ev_ring_id | input | 8 | Event ring id |
| ev_vm_id | input | 8 | Event VM id |
| ev_pasid | input | 16 | Event process address space id |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| db_wr | input | 1 | Doorbell read-pointer write strobe |
| db_rptr | input | PTR_W | Doorbell read-pointer value |
| mem_wr_valid | output | 1 | Memory write issued this cycle |
| mem_wr_addr | output | 40 | Memory byte address |
| mem_wr_data | output | 32 | Memory write data |
| irq | output | 1 | Pending-vector interrupt |

## Verification
The bench sends events until the ring wraps and then fills. It checks that the overflow is flagged on exactly the event that makes the pointers meet. A design with an off-by-one full test would flag one event early or late, or would drop the vector instead of writing it. The bench checks that the flag stays set across a later event and stays in the writeback word. It also checks that irq stays high while the pointers are equal, which a design testing only pointer inequality would miss. Further checks cover both read-pointer paths under each doorbell setting, the masking and alignment of a software read pointer, and the busy window of ev_ready. A design that let the unselected path through, or raised ready during the writeback cycle, would fail these checks.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_BASE = 3'd1;
    localparam logic [2:0] RA_RPTR = 3'd2;
    localparam logic [2:0] RA_WPTR = 3'd3;
    localparam logic [2:0] RA_WBLO = 3'd4;
    localparam logic [2:0] RA_WBHI = 3'd5;

    localparam int VEC_BYTES = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_VEC,
        ST_WB
    } eng_st_e;

    typedef struct packed {
        logic [7:0]  src;
        logic [27:0] data;
        logic [7:0]  ring;
        logic [7:0]  vm;
        logic [15:0] pasid;
    } ivr_event_t;

    function automatic logic [31:0] vec_word(input ivr_event_t e, input logic [1:0] idx);
        logic [31:0] w;
        case (idx)
            2'd0:    w = {24'h0, e.src};
            2'd1:    w = {4'h0, e.data};
            2'd2:    w = {e.pasid, e.vm, e.ring};
            default: w = 32'h0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
    import ivr_pkg::*;
#(
    parameter int PTR_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             db_wr,
    input  logic [PTR_W-1:0] db_rptr,
    input  logic [31:0]      wptr_word,
    output logic             ring_en,
    output logic             int_en,
    output logic             wb_en,
    output logic [PTR_W-1:0] ring_mask,
    output logic [31:0]      base,
    output logic [39:0]      wb_addr,
    output logic [PTR_W-1:0] rptr,
    output logic             ovf_clr,
    output logic             wptr_wr,
    output logic [PTR_W-1:0] wptr_wval
);

    localparam int LOG_MIN = 2;
    localparam int LOG_MAX = PTR_W - 2;
    localparam logic [PTR_W-1:0] ALIGN = {{(PTR_W-4){1'b1}}, 4'h0};

    typedef struct packed {
        logic             ring_en;
        logic             int_en;
        logic             wb_en;
        logic             db_en;
        logic [4:0]       lg;
        logic [31:0]      base;
        logic [PTR_W-1:0] rptr;
        logic [31:0]      wb_lo;
        logic [7:0]       wb_hi;
        logic             ovf_clr;
        logic             wptr_wr;
        logic [PTR_W-1:0] wptr_val;
    } regs_t;

    regs_t            r_d, r_q;
    int               lg_eff;
    logic [PTR_W-1:0] mask_c;
    logic [PTR_W-1:0] ptr_keep;

    always_comb begin
        lg_eff = int'(r_q.lg);
        if (lg_eff < LOG_MIN) lg_eff = LOG_MIN;
        if (lg_eff > LOG_MAX) lg_eff = LOG_MAX;
        for (int i = 0; i < PTR_W; i++) begin
            mask_c[i] = (i < lg_eff + 2);
        end
        ptr_keep = mask_c & ALIGN;

        r_d         = r_q;
        r_d.ovf_clr = 1'b0;
        r_d.wptr_wr = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                RA_CTRL: begin
                    r_d.ring_en = reg_wdata[0];
                    r_d.int_en  = reg_wdata[1];
                    r_d.wb_en   = reg_wdata[2];
                    r_d.db_en   = reg_wdata[3];
                    r_d.lg      = reg_wdata[8:4];
                    r_d.ovf_clr = reg_wdata[31];
                end
                RA_BASE: r_d.base = reg_wdata;
                RA_RPTR: if (!r_q.db_en) r_d.rptr = reg_wdata[PTR_W-1:0] & ptr_keep;
                RA_WPTR: begin
                    r_d.wptr_wr  = 1'b1;
                    r_d.wptr_val = reg_wdata[PTR_W-1:0] & ptr_keep;
                end
                RA_WBLO: r_d.wb_lo = reg_wdata;
                RA_WBHI: r_d.wb_hi = reg_wdata[7:0];
                default: ;
            endcase
        end
        if (db_wr && r_q.db_en) begin
            r_d.rptr = db_rptr & ptr_keep;
        end

        case (reg_addr)
            RA_CTRL: reg_rdata = {23'h0, r_q.lg, r_q.db_en, r_q.wb_en, r_q.int_en, r_q.ring_en};
            RA_BASE: reg_rdata = r_q.base;
            RA_RPTR: reg_rdata = 32'(r_q.rptr);
            RA_WPTR: reg_rdata = wptr_word;
            RA_WBLO: reg_rdata = r_q.wb_lo;
            RA_WBHI: reg_rdata = {24'h0, r_q.wb_hi};
            default: reg_rdata = 32'h0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ring_en   = r_q.ring_en;
    assign int_en    = r_q.int_en;
    assign wb_en     = r_q.wb_en;
    assign ring_mask = mask_c;
    assign base      = r_q.base;
    assign wb_addr   = {r_q.wb_hi, r_q.wb_lo};
    assign rptr      = r_q.rptr;
    assign ovf_clr   = r_q.ovf_clr;
    assign wptr_wr   = r_q.wptr_wr;
    assign wptr_wval = r_q.wptr_val;

endmodule

// File: rtl/ivr_engine.sv
module ivr_engine
    import ivr_pkg::*;
#(
    parameter int PTR_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  ivr_event_t       ev,
    output logic             ev_ready,
    input  logic             ring_en,
    input  logic             wb_en,
    input  logic [PTR_W-1:0] ring_mask,
    input  logic [31:0]      base,
    input  logic [39:0]      wb_addr,
    input  logic [PTR_W-1:0] rptr,
    input  logic             ovf_clr,
    input  logic             wptr_wr,
    input  logic [PTR_W-1:0] wptr_wval,
    output logic             mem_wr_valid,
    output logic [39:0]      mem_wr_addr,
    output logic [31:0]      mem_wr_data,
    output logic [PTR_W-1:0] wptr,
    output logic             ovf,
    output logic [31:0]      wptr_word
);

    typedef struct packed {
        eng_st_e          st;
        logic [1:0]       idx;
        ivr_event_t       evq;
        logic [PTR_W-1:0] wptr;
        logic             ovf;
    } eng_t;

    eng_t             e_d, e_q;
    logic [PTR_W-1:0] step;

    always_comb begin
        e_d          = e_q;
        step         = (e_q.wptr + PTR_W'(VEC_BYTES)) & ring_mask;
        ev_ready     = (e_q.st == ST_IDLE) && ring_en;
        mem_wr_valid = 1'b0;
        mem_wr_addr  = 40'h0;
        mem_wr_data  = 32'h0;
        wptr_word    = 32'(e_q.wptr) | {31'h0, e_q.ovf};

        if (ovf_clr) e_d.ovf = 1'b0;

        case (e_q.st)
            ST_IDLE: begin
                if (ev_valid && ev_ready) begin
                    e_d.evq = ev;
                    e_d.st  = ST_VEC;
                    e_d.idx = 2'd0;
                    if (step == rptr) e_d.ovf = 1'b1;
                end
            end
            ST_VEC: begin
                mem_wr_valid = 1'b1;
                mem_wr_addr  = {base, 8'h00} + {{(40-PTR_W){1'b0}}, e_q.wptr}
                             + {36'h0, e_q.idx, 2'b00};
                mem_wr_data  = vec_word(e_q.evq, e_q.idx);
                e_d.idx      = e_q.idx + 2'd1;
                if (e_q.idx == 2'd3) begin
                    e_d.wptr = step;
                    e_d.st   = wb_en ? ST_WB : ST_IDLE;
                end
            end
            ST_WB: begin
                mem_wr_valid = 1'b1;
                mem_wr_addr  = wb_addr;
                mem_wr_data  = wptr_word;
                e_d.st       = ST_IDLE;
            end
            default: e_d.st = ST_IDLE;
        endcase

        if (wptr_wr) e_d.wptr = wptr_wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign wptr = e_q.wptr;
    assign ovf  = e_q.ovf;

endmodule

// File: rtl/ivr_ring_writer.sv
module ivr_ring_writer
    import ivr_pkg::*;
#(
    parameter int PTR_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    output logic             ev_ready,
    input  logic [7:0]       ev_src_id,
    input  logic [27:0]      ev_src_data,
    input  logic [7:0]       ev_ring_id,
    input  logic [7:0]       ev_vm_id,
    input  logic [15:0]      ev_pasid,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             db_wr,
    input  logic [PTR_W-1:0] db_rptr,
    output logic             mem_wr_valid,
    output logic [39:0]      mem_wr_addr,
    output logic [31:0]      mem_wr_data,
    output logic             irq
);

    ivr_event_t       ev;
    logic             ring_en, int_en, wb_en;
    logic [PTR_W-1:0] ring_mask, rptr, wptr, wptr_wval;
    logic [31:0]      base, wptr_word;
    logic [39:0]      wb_addr;
    logic             ovf_clr, wptr_wr, ovf;

    assign ev = '{src: ev_src_id, data: ev_src_data, ring: ev_ring_id,
                  vm: ev_vm_id, pasid: ev_pasid};

    ivr_regs #(.PTR_W(PTR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .db_wr     (db_wr),
        .db_rptr   (db_rptr),
        .wptr_word (wptr_word),
        .ring_en   (ring_en),
        .int_en    (int_en),
        .wb_en     (wb_en),
        .ring_mask (ring_mask),
        .base      (base),
        .wb_addr   (wb_addr),
        .rptr      (rptr),
        .ovf_clr   (ovf_clr),
        .wptr_wr   (wptr_wr),
        .wptr_wval (wptr_wval)
    );

    ivr_engine #(.PTR_W(PTR_W)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_valid     (ev_valid),
        .ev           (ev),
        .ev_ready     (ev_ready),
        .ring_en      (ring_en),
        .wb_en        (wb_en),
        .ring_mask    (ring_mask),
        .base         (base),
        .wb_addr      (wb_addr),
        .rptr         (rptr),
        .ovf_clr      (ovf_clr),
        .wptr_wr      (wptr_wr),
        .wptr_wval    (wptr_wval),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .wptr         (wptr),
        .ovf          (ovf),
        .wptr_word    (wptr_word)
    );

    assign irq = int_en && ((rptr != wptr) || ovf);

endmodule

// File: rtl/ivr_ring_writer_chk.sv
module ivr_ring_writer_chk #(
    parameter int PTR_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_ready,
    input logic             mem_wr_valid,
    input logic [39:0]      mem_wr_addr,
    input logic             irq,
    input logic             int_en,
    input logic             ovf,
    input logic             ovf_clr,
    input logic             wptr_wr,
    input logic [PTR_W-1:0] wptr,
    input logic [PTR_W-1:0] ring_mask
);

    // R6: no event is taken while a memory write is going out
    assert_busy_no_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> !ev_ready);

    // R1: every write lands on a 32-bit word boundary
    assert_word_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> (mem_wr_addr[1:0] == 2'b00));

    // R4: interrupt is masked by the enable
    assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !irq);

    // R4: a set overflow flag keeps the interrupt up while enabled
    assert_irq_on_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en && ovf) |-> irq);

    // R3: overflow flag is sticky until the clear bit
    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    // R2: hardware moves the pointer only by one wrapped entry
    assert_wptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wptr_wr) && (wptr != $past(wptr)))
            |-> (wptr == (($past(wptr) + PTR_W'(16)) & $past(ring_mask))));

endmodule

bind ivr_ring_writer ivr_ring_writer_chk #(.PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_ready     (ev_ready),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .irq          (irq),
    .int_en       (int_en),
    .ovf          (ovf),
    .ovf_clr      (ovf_clr),
    .wptr_wr      (wptr_wr),
    .wptr         (wptr),
    .ring_mask    (ring_mask)
);

// File: tb/ivr_ring_writer_tb.sv
module ivr_ring_writer_tb;

    localparam int PTR_W = 18;
    localparam logic [39:0] RING = 40'h00_0123_4500;
    localparam logic [39:0] WBA  = 40'hAB_0000_1000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ev_valid = 1'b0;
    logic             ev_ready;
    logic [7:0]       ev_src_id = '0;
    logic [27:0]      ev_src_data = '0;
    logic [7:0]       ev_ring_id = '0;
    logic [7:0]       ev_vm_id = '0;
    logic [15:0]      ev_pasid = '0;
    logic             reg_wr = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             db_wr = 1'b0;
    logic [PTR_W-1:0] db_rptr = '0;
    logic             mem_wr_valid;
    logic [39:0]      mem_wr_addr;
    logic [31:0]      mem_wr_data;
    logic             irq;

    int checks = 0;
    int errors = 0;
    int nw = 0;
    int busy = 0;
    logic [39:0] wa [64];
    logic [31:0] wd [64];

    always #5 clk = ~clk;

    ivr_ring_writer #(.PTR_W(PTR_W)) u_dut (.*);

    always @(negedge clk) begin
        if (mem_wr_valid && nw < 64) begin
            wa[nw] = mem_wr_addr;
            wd[nw] = mem_wr_data;
            nw++;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic doorbell(input logic [PTR_W-1:0] v);
        @(negedge clk);
        db_wr = 1'b1; db_rptr = v;
        @(negedge clk);
        db_wr = 1'b0;
    endtask

    task automatic send(input logic [7:0] s, input logic [27:0] d, input logic [7:0] rg,
                        input logic [7:0] vm, input logic [15:0] pa);
        int guard;
        @(negedge clk);
        ev_valid = 1'b1; ev_src_id = s; ev_src_data = d;
        ev_ring_id = rg; ev_vm_id = vm; ev_pasid = pa;
        guard = 0;
        while (!ev_ready && guard < 20) begin @(negedge clk); guard++; end
        @(negedge clk);
        ev_valid = 1'b0;
        busy = 0;
        while (!ev_ready && busy < 12) begin busy++; @(negedge clk); end
    endtask

    task automatic chk_vec(input int i, input logic [39:0] a, input logic [7:0] s,
                           input logic [27:0] d, input logic [7:0] rg,
                           input logic [7:0] vm, input logic [15:0] pa);
        chk("R1 addr w0", wa[i], a);
        chk("R1 addr w1", wa[i+1], a + 40'd4);
        chk("R1 addr w2", wa[i+2], a + 40'd8);
        chk("R1 addr w3", wa[i+3], a + 40'd12);
        chk("R1 word0 src", wd[i], {24'h0, s});
        chk("R1 word1 data", wd[i+1], {4'h0, d});
        chk("R1 word2 ids", wd[i+2], {pa, vm, rg});
        chk("R1 word3 zero", wd[i+3], 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); chk("R8 ctrl reset", v, 0);
        rd(3'd2, v); chk("R8 rptr reset", v, 0);
        rd(3'd3, v); chk("R8 wptr reset", v, 0);
        chk("R8 irq reset", irq, 0);
        chk("R6 ready with ring off", ev_ready, 0);
        chk("R8 no write after reset", nw, 0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        wr(3'd1, 32'h0001_2345);
        wr(3'd4, 32'h0000_1000);
        wr(3'd5, 32'h0000_00AB);
        wr(3'd0, 32'h47);
        rd(3'd0, v); chk("R2 ctrl readback", v, 32'h47);
        nw = 0;
        send(8'hA5, 28'hFEDCBA9, 8'h03, 8'h07, 16'hBEEF);
        chk("R5 write count with wb", nw, 5);
        chk_vec(0, RING, 8'hA5, 28'hFEDCBA9, 8'h03, 8'h07, 16'hBEEF);
        chk("R5 wb addr", wa[4], WBA);
        chk("R5 wb data", wd[4], 32'h10);
        chk("R6 busy cycles with wb", busy, 5);
        rd(3'd3, v); chk("R2 wptr after one", v, 32'h10);
        chk("R4 irq pending", irq, 1);
        wr(3'd2, 32'h10);
        chk("R4 irq after ack", irq, 0);
    endtask

    task automatic t_wrap_ovf();
        logic [31:0] v;
        send(8'h01, 28'h1, 8'h0, 8'h0, 16'h0);
        send(8'h02, 28'h2, 8'h0, 8'h0, 16'h0);
        nw = 0;
        send(8'h03, 28'h3, 8'h1, 8'h2, 16'h3);
        chk_vec(0, RING + 40'h30, 8'h03, 28'h3, 8'h1, 8'h2, 16'h3);
        rd(3'd3, v); chk("R2 wptr wraps", v, 32'h0);
        chk("R5 wb after wrap", wd[4], 32'h0);
        nw = 0;
        send(8'h04, 28'h4, 8'h0, 8'h0, 16'h0);
        chk("R3 full vector still written", wa[0], RING);
        rd(3'd3, v); chk("R3 overflow flagged", v, 32'h11);
        chk("R3 wb carries flag", wd[4], 32'h11);
        chk("R4 irq on overflow with equal ptrs", irq, 1);
        send(8'h05, 28'h5, 8'h0, 8'h0, 16'h0);
        rd(3'd3, v); chk("R3 flag sticky", v, 32'h21);
        wr(3'd0, 32'h8000_0047);
        rd(3'd3, v); chk("R3 flag cleared", v, 32'h20);
        rd(3'd0, v); chk("R3 clear bit reads zero", v, 32'h47);
        wr(3'd2, 32'h20);
        chk("R4 irq idle after clear", irq, 0);
    endtask

    task automatic t_plain();
        logic [31:0] v;
        wr(3'd0, 32'h41);
        nw = 0;
        send(8'h06, 28'h6, 8'h0, 8'h0, 16'h0);
        chk("R5 no wb write", nw, 4);
        chk("R6 busy cycles without wb", busy, 4);
        rd(3'd3, v); chk("R2 wptr advance", v, 32'h30);
        chk("R4 irq masked", irq, 0);
        wr(3'd0, 32'h43);
        chk("R4 irq unmasked", irq, 1);
    endtask

    task automatic t_doorbell();
        logic [31:0] v;
        doorbell(18'h30);
        rd(3'd2, v); chk("R7 doorbell ignored", v, 32'h20);
        wr(3'd2, 32'h5F);
        rd(3'd2, v); chk("R7 reg rptr masked", v, 32'h10);
        wr(3'd0, 32'h4B);
        wr(3'd2, 32'h30);
        rd(3'd2, v); chk("R7 reg rptr ignored", v, 32'h10);
        doorbell(18'h3_FFF7);
        rd(3'd2, v); chk("R7 doorbell rptr", v, 32'h30);
        chk("R4 irq after doorbell", irq, 0);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        wr(3'd0, 32'h0);
        nw = 0;
        @(negedge clk);
        ev_valid = 1'b1;
        repeat (6) begin
            @(negedge clk);
            if (ev_ready) chk("R6 ready while disabled", ev_ready, 0);
        end
        ev_valid = 1'b0;
        chk("R6 no write when disabled", nw, 0);
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h0);
        wr(3'd0, 32'h42);
        rd(3'd3, v); chk("R8 wptr zeroed", v, 0);
        rd(3'd2, v); chk("R8 rptr zeroed", v, 0);
        chk("R8 ring empty irq", irq, 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_wrap_ovf();
        t_plain();
        t_doorbell();
        t_disable();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule